// File: doc/BRIEF.md
# Stopwatch Timer with Interrupt Registers

A small peripheral that keeps a two-digit decimal stopwatch for a 4-bit microcontroller. The low digit counts hundredths of a second and the high digit counts tenths. Both digits are BCD and the CPU reads them over a synchronous nibble-wide register bus. The count advances on a 100 Hz tick supplied from outside the block. Software starts and stops the count with a run bit, and it clears both digits by writing a self-clearing reset bit.

Each time the hundredths digit rolls over, the block latches a 10 Hz event flag. Each time the tenths digit rolls over, it latches a 1 Hz event flag. Each flag has its own enable mask. A single interrupt request line goes high while any flag is set and enabled. Software acknowledges the events by reading the flag register, and that read clears the flags.

Bus timing: the address and strobes are sampled on the rising clock edge. Read data is combinational while the read strobe is high. Every register update, including the clearing of a flag on a read, happens at the edge that ends the access.

Top module: `swtimer_top`

## Requirements
- R1: The hundredths digit reads at address 0x2E1 and the tenths digit reads at 0x2E2, each as a BCD value in bits 3:0. Both digits are 0 after reset.
- R2: Writes to 0x2E1, 0x2E2 and 0x2EA change no digit and no flag.
- R3: At 0x2E6, bit 0 is the 10 Hz enable mask and bit 1 is the 1 Hz enable mask. Both read back as written and are 0 after reset.
- R4: At 0x2EA, bit 0 is the 10 Hz flag and bit 1 is the 1 Hz flag. Both are 0 after reset.
- R5: A read of 0x2EA returns the current flags and clears both flags at the end of that read cycle.
- R6: At 0x2EE, bit 2 is the run control (1 = run) and it reads back. It is 0 after reset. While it is 0, ticks leave the digits unchanged.
- R7: Writing 1 to bit 1 of 0x2EE sets both digits to 0 at that edge, even when a tick arrives in the same cycle. Bit 1 always reads 0.
- R8: While running, each tick advances the hundredths digit through 0..9. Its wrap from 9 to 0 advances the tenths digit through 0..9, so the pair counts 0..99 and then wraps.
- R9: A hundredths wrap sets the 10 Hz flag, and a tenths wrap sets the 1 Hz flag, whatever the state of the masks.
- R10: irq is 1 exactly when some flag is 1 and its mask bit is also 1.
- R11: When a wrap and a read of 0x2EA fall in the same cycle, the flag for that wrap is 1 after the edge.
- R12: Unused bits of the block's registers, every other address, and any cycle with the read strobe low all return 0 on rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 4 | Write data nibble |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 4 | Read data, valid while bus_rd is high |
| tick_100hz | input | 1 | Count enable, one cycle at 100 Hz |
| irq | output | 1 | Interrupt request |

## Verification
The bench keeps a decimal model of the count and of both flags and sweeps the count through more than two full cycles of 0..99. After every tick it reads both digits and the flag register. With this sweep, a wrong carry or a digit leaving the BCD range shows up on the port reads at the very next tick. A lost or extra flag shows up at the flag read that follows the wrap. Run/stop, clear priority, read-versus-set collisions and the mask gating of irq are each driven directly. Their results are sampled in the cycle just after the edge that should change them.

// File: rtl/swt_pkg.sv
package swt_pkg;

    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 4;
    localparam int NUM_DIGITS = 2;
    localparam int DIGIT_MAX  = 9;
    localparam int NUM_SRC    = NUM_DIGITS;

    localparam logic [ADDR_W-1:0] A_DIG_LO = 12'h2E1;
    localparam logic [ADDR_W-1:0] A_DIG_HI = 12'h2E2;
    localparam logic [ADDR_W-1:0] A_MASK   = 12'h2E6;
    localparam logic [ADDR_W-1:0] A_FLAG   = 12'h2EA;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h2EE;

    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_RUN_BIT = 2;

    typedef logic [DATA_W-1:0] nib_t;

    typedef struct packed {
        logic ctrl;
        logic flag;
        logic mask;
        logic dig_hi;
        logic dig_lo;
    } sel_t;

    function automatic sel_t decode(input logic [ADDR_W-1:0] a);
        sel_t s;
        s.dig_lo = (a == A_DIG_LO);
        s.dig_hi = (a == A_DIG_HI);
        s.mask   = (a == A_MASK);
        s.flag   = (a == A_FLAG);
        s.ctrl   = (a == A_CTRL);
        return s;
    endfunction

    function automatic nib_t bcd_step(input nib_t d, input int unsigned top);
        return (d == nib_t'(top)) ? '0 : d + nib_t'(1);
    endfunction

endpackage

// File: rtl/swt_bcd_digit.sv
module swt_bcd_digit
    import swt_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int MAX = DIGIT_MAX
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         carry
);

    logic [W-1:0] val_q;

    assign carry = inc && (val_q == W'(MAX));
    assign value = val_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            val_q <= '0;
        end else if (inc) begin
            val_q <= (val_q == W'(MAX)) ? '0 : val_q + W'(1);
        end
    end

    assert_digit_range_R8 : assert property (@(posedge clk) disable iff (rst)
        val_q <= W'(MAX));

    assert_digit_clear_R7 : assert property (@(posedge clk) disable iff (rst)
        clr |=> (val_q == '0));

endmodule

// File: rtl/swt_irq_unit.sv
module swt_irq_unit
    import swt_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         rd_clr,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] mask,
    output logic [N-1:0] flag,
    output logic         irq
);

    logic [N-1:0] mask_q;
    logic [N-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_wdata;
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q[i] <= 1'b0;
                end else if (evt[i]) begin
                    flag_q[i] <= 1'b1;
                end else if (rd_clr) begin
                    flag_q[i] <= 1'b0;
                end
            end

            assert_flag_set_R9 : assert property (@(posedge clk) disable iff (rst)
                evt[i] |=> flag_q[i]);

            assert_read_clears_R5 : assert property (@(posedge clk) disable iff (rst)
                (rd_clr && !evt[i]) |=> !flag_q[i]);
        end
    endgenerate

    assign mask = mask_q;
    assign flag = flag_q;
    assign irq  = |(flag_q & mask_q);

endmodule

// File: rtl/swtimer_top.sv
module swtimer_top
    import swt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_100hz,
    output logic          irq
);

    localparam int ND = NUM_DIGITS;

    sel_t sel;
    logic run_q;
    logic clr_w;
    logic [ND:0] carry;
    logic [ND-1:0][DW-1:0] digit;
    logic [ND-1:0] mask;
    logic [ND-1:0] flag;

    assign sel   = decode(ADDR_W'(bus_addr));
    assign clr_w = bus_wr && sel.ctrl && bus_wdata[CTRL_CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else if (bus_wr && sel.ctrl) begin
            run_q <= bus_wdata[CTRL_RUN_BIT];
        end
    end

    assign carry[0] = run_q && tick_100hz && !clr_w;

    generate
        for (genvar d = 0; d < ND; d++) begin : g_dig
            swt_bcd_digit #(.W(DW), .MAX(DIGIT_MAX)) u_digit (
                .clk   (clk),
                .rst   (rst),
                .clr   (clr_w),
                .inc   (carry[d]),
                .value (digit[d]),
                .carry (carry[d+1])
            );
        end
    endgenerate

    swt_irq_unit #(.N(ND)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .evt        (carry[ND:1]),
        .rd_clr     (bus_rd && sel.flag),
        .mask_wr    (bus_wr && sel.mask),
        .mask_wdata (bus_wdata[ND-1:0]),
        .mask       (mask),
        .flag       (flag),
        .irq        (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel.dig_lo) bus_rdata = digit[0];
            if (sel.dig_hi) bus_rdata = digit[1];
            if (sel.mask)   bus_rdata[ND-1:0] = mask;
            if (sel.flag)   bus_rdata[ND-1:0] = flag;
            if (sel.ctrl)   bus_rdata[CTRL_RUN_BIT] = run_q;
        end
    end

    assert_stopped_hold_R6 : assert property (@(posedge clk) disable iff (rst)
        (!run_q && !clr_w) |=> $stable(digit));

    assert_idle_bus_quiet_R12 : assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));

    assert_irq_needs_flag_R10 : assert property (@(posedge clk) disable iff (rst)
        (flag == '0) |-> !irq);

endmodule

// File: tb/swtimer_top_test.sv
module swtimer_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_rdata;
    logic        tick_100hz = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    int cnt = 0;
    int ef10 = 0;
    int ef1 = 0;
    int got;

    always #2.5 clk = ~clk;

    swtimer_top uut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .tick_100hz (tick_100hz),
        .irq        (irq)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [3:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output int v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    // model of one running tick
    task automatic model_tick();
        if (cnt % 10 == 9) ef10 = 1;
        if (cnt == 99) ef1 = 1;
        cnt = (cnt + 1) % 100;
    endtask

    task automatic tick_once();
        tick_100hz = 1'b1;
        @(negedge clk);
        tick_100hz = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        bus_read(12'h2E1, got); check("R1 lo reset", got, 0);
        bus_read(12'h2E2, got); check("R1 hi reset", got, 0);
        bus_read(12'h2E6, got); check("R3 mask reset", got, 0);
        bus_read(12'h2EA, got); check("R4 flag reset", got, 0);
        bus_read(12'h2EE, got); check("R6 ctrl reset", got, 0);
        #1 check("R10 irq reset", int'(irq), 0);

        // unused addresses and idle strobe
        bus_read(12'h2E0, got); check("R12 addr 2E0", got, 0);
        bus_read(12'h2EF, got); check("R12 addr 2EF", got, 0);
        bus_read(12'h000, got); check("R12 addr 000", got, 0);
        bus_addr = 12'h2E6; #1 check("R12 rd low", int'(bus_rdata), 0);
        bus_addr = '0;

        // mask sweep, upper bits read 0
        for (int m = 0; m < 16; m++) begin
            bus_write(12'h2E6, 4'(m));
            bus_read(12'h2E6, got);
            check("R3 mask readback", got, m & 3);
        end
        bus_write(12'h2E6, 4'h0);

        // stopped: ticks ignored
        for (int i = 0; i < 5; i++) tick_once();
        bus_read(12'h2E1, got); check("R6 stopped lo", got, 0);
        bus_read(12'h2EA, got); check("R6 stopped flags", got, 0);

        // run; bit1 reads 0, bit3/bit0 read 0
        bus_write(12'h2EE, 4'b1101);
        bus_read(12'h2EE, got); check("R6 R12 ctrl readback", got, 4);

        // exhaustive sweep over 250 ticks
        for (int i = 0; i < 250; i++) begin
            tick_once(); model_tick();
            bus_read(12'h2E1, got); check("R8 lo digit", got, cnt % 10);
            bus_read(12'h2E2, got); check("R8 hi digit", got, cnt / 10);
            bus_read(12'h2EA, got); check("R9 R5 flags", got, ef10 + 2 * ef1);
            ef10 = 0; ef1 = 0;
        end
        bus_read(12'h2EA, got); check("R5 flags cleared", got, 0);

        // writes to read-only registers ignored
        bus_write(12'h2E1, 4'h7);
        bus_write(12'h2E2, 4'h3);
        bus_write(12'h2EA, 4'h3);
        bus_read(12'h2E1, got); check("R2 lo unchanged", got, cnt % 10);
        bus_read(12'h2E2, got); check("R2 hi unchanged", got, cnt / 10);
        bus_read(12'h2EA, got); check("R2 flags unchanged", got, 0);

        // advance to 99 with masks off, flags still set
        while (cnt != 99) begin tick_once(); model_tick(); end
        tick_once(); model_tick();
        #1 check("R10 irq masked", int'(irq), 0);
        bus_write(12'h2E6, 4'b0010);
        #1 check("R10 irq 1Hz enabled", int'(irq), 1);
        bus_write(12'h2E6, 4'b0001);
        #1 check("R10 irq 10Hz enabled", int'(irq), 1);
        bus_read(12'h2EA, got); check("R9 both flags mask-free", got, 3);
        ef10 = 0; ef1 = 0;
        #1 check("R10 irq after clear", int'(irq), 0);

        // only 10Hz flag with only 1Hz mask -> no irq
        bus_write(12'h2E6, 4'b0010);
        for (int i = 0; i < 10; i++) begin tick_once(); model_tick(); end
        #1 check("R10 irq wrong mask", int'(irq), 0);
        bus_read(12'h2EA, got); check("R9 10Hz only", got, 1);
        ef10 = 0;

        // set wins over read clear
        while (cnt % 10 != 9) begin tick_once(); model_tick(); end
        bus_read(12'h2EA, got); ef10 = 0; ef1 = 0;
        bus_addr = 12'h2EA; bus_rd = 1'b1; tick_100hz = 1'b1;
        #1 check("R11 read during wrap old", int'(bus_rdata), 0);
        @(negedge clk);
        bus_rd = 1'b0; tick_100hz = 1'b0; bus_addr = '0;
        model_tick();
        bus_read(12'h2EA, got); check("R11 flag survived", got, ef10 + 2 * ef1);
        ef10 = 0; ef1 = 0;

        // clear wins over tick, run kept
        for (int i = 0; i < 3; i++) begin tick_once(); model_tick(); end
        bus_addr = 12'h2EE; bus_wdata = 4'b0110; bus_wr = 1'b1; tick_100hz = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_100hz = 1'b0; bus_addr = '0; bus_wdata = '0;
        cnt = 0;
        bus_read(12'h2E1, got); check("R7 lo cleared", got, 0);
        bus_read(12'h2E2, got); check("R7 hi cleared", got, 0);
        bus_read(12'h2EE, got); check("R7 clr bit reads 0", got, 4);
        bus_read(12'h2EA, got); check("R7 no flag on clear", got, 0);
        tick_once(); model_tick();
        bus_read(12'h2E1, got); check("R7 counts after clear", got, 1);

        // stop holds value
        bus_write(12'h2EE, 4'b0000);
        for (int i = 0; i < 4; i++) tick_once();
        bus_read(12'h2E1, got); check("R6 stop holds", got, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule